// File: doc/BRIEF.md
# Dual-Mode Peripheral Expansion Port

This block runs an eleven-pin expansion port behind a small host register interface. A mode bit decides what the pins do. With the bit clear, every pin is an independent general-purpose line: it has its own direction bit and its own output data bit, and the level on the pin can be read back through a two-stage synchronizer. With the bit set, the same pins form a byte-wide multiplexed address/data bus. The three upper pins carry an address-latch pulse, a read strobe and a write strobe, all active low except the latch pulse.

In bus mode the host writes an address register, and for a write it also writes a data register. It can set the strobe length in clocks. A write to the command register then starts one bus cycle. The cycle has three phases in this order: the address is driven with the latch pulse low, then high, then low again; the strobe phase follows; at the end the data lines are released. The busy flag stays up for the whole cycle. When a read cycle ends, the byte taken from the pads is in the data register. The pin registers used in general-purpose mode keep their values while the port is in bus mode and take effect again when the port returns to that mode.

Top module: `xport_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After it, every pad output enable is 0, the effective mode is 0, and the registers at offsets 0 (CTRL), 1 (DIR), 2 (OUT), 5 (DATA) and 6 (CMD) read as 0.
- R2: In mode 0, pad_oe[i] equals DIR bit i (1 = drive) and pad_out[i] equals OUT bit i for all 11 pins.
- R3: Offset 3 (IN) returns the pad levels through two flops. A pad change set up before clock edge k reads back after edge k+1 and not earlier.
- R4: In mode 1, pins 10, 9 and 8 are always driven and idle at 1, 1 and 0 (write strobe, read strobe, latch pulse). Pins 7..0 are released when the port is idle. DIR and OUT keep their values and drive the pads again once mode 0 is back in effect.
- R5: A write cycle drives the address on pins 7..0 for three clocks while the latch pulse is 0, 1 and 0. It then drives the DATA byte with the write strobe at 0 for N clocks, and then releases pins 7..0.
- R6: A read cycle uses the same address phase. It then releases pins 7..0 and holds the read strobe at 0 for N clocks. DATA takes pad_in[7:0] as sampled at the clock edge that ends the last strobe clock, and later pad changes do not alter it.
- R7: CMD bit 0 reads 1 (busy) for exactly 3+N clocks from the clock after the command write.
- R8: N is the 4-bit value at offset 7 (STRB). A value of 0 gives one strobe clock.
- R9: A write to CTRL bit 0 (1 = bus mode) takes effect on the second clock after the write, or on the second clock after busy falls if a cycle is in progress. While the cycle runs, the pins keep their bus roles and CTRL reads the old mode.
- R10: A CMD write (bit 0: 1 = write cycle, 0 = read cycle) is ignored in mode 0 or while busy.
- R11: While the read strobe is low, pins 7..0 are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Register write enable |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data (combinational) |
| pad_in | input | 11 | Level seen at each pad |
| pad_out | output | 11 | Value driven onto each pad |
| pad_oe | output | 11 | Pad driver enable, 1 = drive |

## Verification
A sequencer that is stuck or has lost a state shows up at the ports at the very next clock. The pin 8..10 pattern or the enable on pins 7..0 departs from the fixed three-clock address phase, and the busy bit stays high or drops one clock off from 3+N. A wrong strobe counter shows as a strobe that is one clock too long or too short, or as a read byte taken from the wrong clock: the pad value is changed on the first strobe clock and changed again after the cycle, so a capture on the wrong edge returns the wrong byte. A mode register that switches while the bus is busy shows as pins 8..10 losing their drive within one clock.

// File: rtl/xport_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the expansion port: register offsets and the
// bus-cycle sequencer state encoding.
package xport_pkg;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_DIR  = 3'd1;
    localparam logic [2:0] RA_OUT  = 3'd2;
    localparam logic [2:0] RA_IN   = 3'd3;
    localparam logic [2:0] RA_ADDR = 3'd4;
    localparam logic [2:0] RA_DATA = 3'd5;
    localparam logic [2:0] RA_CMD  = 3'd6;
    localparam logic [2:0] RA_STRB = 3'd7;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_ADDR = 3'd1,
        SQ_ALE  = 3'd2,
        SQ_HOLD = 3'd3,
        SQ_STRB = 3'd4
    } sq_state_e;

endpackage

// File: rtl/xport_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for the pad levels.
// Assumes: every bit may change at any time relative to clk; the bits are
// not related to one another, so no coherence across bits is given.
module xport_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Purpose: pass the raw pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

endmodule

// File: rtl/xport_regs.sv
`timescale 1ns/1ps
// Host register file for the expansion port.
// Holds mode, pin direction/output, bus address/data and strobe length,
// gates bus-cycle launch, and defers a mode change until the sequencer
// is idle. Assumes: single-cycle host writes, combinational reads.
module xport_regs
    import xport_pkg::*;
#(
    parameter int NP  = 11,
    parameter int ADW = 8,
    parameter int SW  = 4,
    parameter int HDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_we,
    input  logic [2:0]     host_addr,
    input  logic [HDW-1:0] host_wdata,
    output logic [HDW-1:0] host_rdata,
    input  logic [NP-1:0]  in_sync,
    input  logic           busy,
    input  logic           cap_en,
    input  logic [ADW-1:0] cap_data,
    output logic           mode,
    output logic [NP-1:0]  dir,
    output logic [NP-1:0]  out,
    output logic [ADW-1:0] bus_addr,
    output logic [ADW-1:0] bus_data,
    output logic [SW-1:0]  strb_len,
    output logic           start,
    output logic           start_wr
);

    logic           mode_req_q;
    logic           mode_q;
    logic [NP-1:0]  dir_q;
    logic [NP-1:0]  out_q;
    logic [ADW-1:0] addr_q;
    logic [ADW-1:0] data_q;
    logic [SW-1:0]  strb_q;
    logic           unused_wbits;

    assign unused_wbits = ^host_wdata[HDW-1:NP];

    // Purpose: host writes, read-data capture and deferred mode update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_req_q <= 1'b0;
            mode_q     <= 1'b0;
            dir_q      <= '0;
            out_q      <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            strb_q     <= '0;
        end else begin
            if (host_we) begin
                case (host_addr)
                    RA_CTRL: mode_req_q <= host_wdata[0];
                    RA_DIR:  dir_q      <= host_wdata[NP-1:0];
                    RA_OUT:  out_q      <= host_wdata[NP-1:0];
                    RA_ADDR: addr_q     <= host_wdata[ADW-1:0];
                    RA_DATA: data_q     <= host_wdata[ADW-1:0];
                    RA_STRB: strb_q     <= host_wdata[SW-1:0];
                    default: ;
                endcase
            end
            if (cap_en) begin
                data_q <= cap_data;
            end
            if (!busy) begin
                mode_q <= mode_req_q;
            end
        end
    end

    // Purpose: launch a bus cycle only in bus mode with the sequencer idle.
    always_comb begin
        start    = host_we && (host_addr == RA_CMD) && mode_q && !busy;
        start_wr = host_wdata[0];
    end

    // Purpose: combinational register read-back.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            RA_CTRL: host_rdata[0]        = mode_q;
            RA_DIR:  host_rdata[NP-1:0]   = dir_q;
            RA_OUT:  host_rdata[NP-1:0]   = out_q;
            RA_IN:   host_rdata[NP-1:0]   = in_sync;
            RA_ADDR: host_rdata[ADW-1:0]  = addr_q;
            RA_DATA: host_rdata[ADW-1:0]  = data_q;
            RA_CMD:  host_rdata[0]        = busy;
            RA_STRB: host_rdata[SW-1:0]   = strb_q;
            default: host_rdata           = '0;
        endcase
    end

    assign mode     = mode_q;
    assign dir      = dir_q;
    assign out      = out_q;
    assign bus_addr = addr_q;
    assign bus_data = data_q;
    assign strb_len = strb_q;

    // R1: leaving reset, mode and pin registers are cleared.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mode_q && dir_q == '0 && out_q == '0));

    // R9: the effective mode never changes across a busy clock.
    p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/xport_seq.sv
`timescale 1ns/1ps
// Bus-cycle sequencer for multiplexed address/data mode.
// Runs address, latch-high, latch-low hold, then N strobe clocks; captures
// read data on the last strobe clock. Assumes start only arrives when idle.
module xport_seq
    import xport_pkg::*;
#(
    parameter int ADW = 8,
    parameter int SW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_wr,
    input  logic [ADW-1:0] bus_addr,
    input  logic [ADW-1:0] bus_data,
    input  logic [SW-1:0]  strb_len,
    input  logic [ADW-1:0] pad_ad_in,
    output logic           busy,
    output logic           ad_oe,
    output logic [ADW-1:0] ad_out,
    output logic           ale,
    output logic           rd_n,
    output logic           wr_n,
    output logic           cap_en,
    output logic [ADW-1:0] cap_data
);

    sq_state_e      state_q;
    logic           is_wr_q;
    logic [ADW-1:0] addr_q;
    logic [ADW-1:0] data_q;
    logic [SW-1:0]  cnt_q;
    logic [SW-1:0]  len_m1;

    // Purpose: strobe clocks minus one, a zero length counting as one.
    assign len_m1 = (strb_len == '0) ? '0 : SW'(strb_len - 1'b1);

    // Purpose: phase progression and strobe counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            is_wr_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) begin
                    state_q <= SQ_ADDR;
                    is_wr_q <= start_wr;
                    addr_q  <= bus_addr;
                    data_q  <= bus_data;
                    cnt_q   <= len_m1;
                end
                SQ_ADDR: state_q <= SQ_ALE;
                SQ_ALE:  state_q <= SQ_HOLD;
                SQ_HOLD: state_q <= SQ_STRB;
                SQ_STRB: begin
                    if (cnt_q == '0) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Purpose: decode pin controls from the current phase.
    always_comb begin
        busy     = (state_q != SQ_IDLE);
        ale      = (state_q == SQ_ALE);
        rd_n     = !((state_q == SQ_STRB) && !is_wr_q);
        wr_n     = !((state_q == SQ_STRB) && is_wr_q);
        ad_oe    = (state_q == SQ_ADDR) || (state_q == SQ_ALE) ||
                   (state_q == SQ_HOLD) || ((state_q == SQ_STRB) && is_wr_q);
        ad_out   = (state_q == SQ_STRB) ? data_q : addr_q;
        cap_en   = (state_q == SQ_STRB) && !is_wr_q && (cnt_q == '0);
        cap_data = pad_ad_in;
    end

    // R5: a launch puts the address on the bus with all strobes idle.
    p_launch_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && ad_oe && !ale && rd_n && wr_n));

    // R5: after the latch pulse falls the address is still held.
    p_hold_after_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && rd_n && wr_n));

    // R5: write strobe only with data driven.
    p_wr_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    // R11: read strobe only with the data lines released.
    p_rd_floats_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R6: capture is the last strobe clock; the cycle ends right after.
    p_cap_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (rd_n && !busy));

endmodule

// File: rtl/xport_pinmux.sv
`timescale 1ns/1ps
// Pad multiplexer: per pin, selects general-purpose direction/data or the
// bus role (address/data, latch pulse, read strobe, write strobe).
// Assumes NP == ADW + 3, control pins directly above the data pins.
module xport_pinmux #(
    parameter int NP  = 11,
    parameter int ADW = 8
) (
    input  logic           mode,
    input  logic [NP-1:0]  dir,
    input  logic [NP-1:0]  out,
    input  logic           ad_oe,
    input  logic [ADW-1:0] ad_out,
    input  logic           ale,
    input  logic           rd_n,
    input  logic           wr_n,
    output logic [NP-1:0]  pad_oe,
    output logic [NP-1:0]  pad_out
);

    logic [NP-1:0] bus_oe;
    logic [NP-1:0] bus_out;

    // Purpose: assemble the bus-mode view of all pins.
    always_comb begin
        bus_oe  = {3'b111, {ADW{ad_oe}}};
        bus_out = {wr_n, rd_n, ale, ad_out};
    end

    for (genvar gi = 0; gi < NP; gi++) begin : g_pin
        // Purpose: per-pin selection between the two modes.
        assign pad_oe[gi]  = mode ? bus_oe[gi]  : dir[gi];
        assign pad_out[gi] = mode ? bus_out[gi] : out[gi];
    end

endmodule

// File: rtl/xport_ctrl.sv
`timescale 1ns/1ps
// Top of the dual-mode expansion port.
// Ties together register file, pad synchronizer, bus sequencer and pad mux.
// Assumes an external tristate pad per pin using pad_oe / pad_out / pad_in.
module xport_ctrl #(
    parameter int ADW = 8,
    parameter int SW  = 4,
    parameter int HDW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [HDW-1:0]    host_wdata,
    output logic [HDW-1:0]    host_rdata,
    input  logic [ADW+2:0]    pad_in,
    output logic [ADW+2:0]    pad_out,
    output logic [ADW+2:0]    pad_oe
);

    localparam int NPINS = ADW + 3;

    logic [NPINS-1:0] in_sync;
    logic             mode_eff;
    logic [NPINS-1:0] dir_r;
    logic [NPINS-1:0] out_r;
    logic [ADW-1:0]   bus_addr;
    logic [ADW-1:0]   bus_data;
    logic [SW-1:0]    strb_len;
    logic             start;
    logic             start_wr;
    logic             busy;
    logic             cap_en;
    logic [ADW-1:0]   cap_data;
    logic             ad_oe;
    logic [ADW-1:0]   ad_out;
    logic             ale;
    logic             rd_n;
    logic             wr_n;

    xport_sync #(.W(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .d_sync  (in_sync)
    );

    xport_regs #(.NP(NPINS), .ADW(ADW), .SW(SW), .HDW(HDW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .in_sync    (in_sync),
        .busy       (busy),
        .cap_en     (cap_en),
        .cap_data   (cap_data),
        .mode       (mode_eff),
        .dir        (dir_r),
        .out        (out_r),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .strb_len   (strb_len),
        .start      (start),
        .start_wr   (start_wr)
    );

    xport_seq #(.ADW(ADW), .SW(SW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_wr  (start_wr),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .strb_len  (strb_len),
        .pad_ad_in (pad_in[ADW-1:0]),
        .busy      (busy),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .cap_en    (cap_en),
        .cap_data  (cap_data)
    );

    xport_pinmux #(.NP(NPINS), .ADW(ADW)) u_pinmux (
        .mode    (mode_eff),
        .dir     (dir_r),
        .out     (out_r),
        .ad_oe   (ad_oe),
        .ad_out  (ad_out),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    // R4: in bus mode the three control pins are always driven.
    p_bus_ctl_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_eff |-> (pad_oe[NPINS-1:ADW] == '1));

endmodule

// File: tb/xport_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench for xport_ctrl: a vector table for general-purpose
// mode, then directed bus-cycle, deferral and ignore tests.
module xport_ctrl_bench;

    logic        clk;
    logic        rst_n;
    logic        host_we;
    logic [2:0]  host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic [10:0] pad_in;
    logic [10:0] pad_out;
    logic [10:0] pad_oe;

    int checks;
    int errors;

    // dir[32:22], out[21:11], pin level[10:0]
    localparam logic [32:0] GV [6] = '{
        {11'h000, 11'h7FF, 11'h555},
        {11'h7FF, 11'h2AA, 11'h2AA},
        {11'h0F0, 11'h0FF, 11'h7FF},
        {11'h401, 11'h400, 11'h000},
        {11'h30C, 11'h7F3, 11'h123},
        {11'h555, 11'h555, 11'h6DB}
    };

    xport_ctrl u_xport_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic host_write(input logic [2:0] a, input logic [15:0] d);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [15:0] v);
        host_addr = a;
        #0.2;
        v = host_rdata;
    endtask

    // Runs one bus cycle and checks every clock of it.
    task automatic bus_cycle(input bit wr, input logic [7:0] a, input logic [7:0] d,
                             input logic [3:0] nreg, input logic [7:0] rv);
        logic [15:0] v;
        int n;
        string tg;
        n  = (nreg == 0) ? 1 : int'(nreg);
        tg = wr ? "R5" : "R6";
        host_write(3'd4, {8'h00, a});
        host_write(3'd5, {8'h00, d});
        host_write(3'd7, {12'h000, nreg});
        pad_in[7:0] = ~rv;
        host_write(3'd6, {15'h0, wr});
        for (int i = 0; i < 3 + n; i++) begin
            logic       exp_oe;
            logic [2:0] exp_ctl;
            if (!wr && i == 3) pad_in[7:0] = rv;
            exp_oe  = (i < 3) || wr;
            exp_ctl = {!(wr && i >= 3), !(!wr && i >= 3), (i == 1)};
            chk(tg, pad_oe, {3'b111, {8{exp_oe}}});
            chk(tg, pad_out[10:8], exp_ctl);
            if (exp_oe) chk(tg, pad_out[7:0], (i < 3) ? a : d);
            host_read(3'd6, v);
            chk("R7", v[0], 1'b1);
            @(negedge clk);
        end
        host_read(3'd6, v);
        chk("R8", v[0], 1'b0);
        chk("R4", pad_oe, 11'h700);
        chk("R4", pad_out[10:8], 3'b110);
        host_read(3'd5, v);
        chk(tg, v[7:0], wr ? d : rv);
        if (!wr) begin
            pad_in[7:0] = ~rv;
            @(negedge clk);
            host_read(3'd5, v);
            chk("R6", v[7:0], rv);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [10:0] prev_pin;
        checks     = 0;
        errors     = 0;
        rst_n      = 1'b0;
        host_we    = 1'b0;
        host_addr  = 3'd0;
        host_wdata = 16'h0;
        pad_in     = 11'h0;
        repeat (3) @(negedge clk);
        chk("R1", pad_oe, 11'h000);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        host_read(3'd0, v); chk("R1", v, 16'h0);
        host_read(3'd1, v); chk("R1", v, 16'h0);
        host_read(3'd2, v); chk("R1", v, 16'h0);
        host_read(3'd5, v); chk("R1", v, 16'h0);
        host_read(3'd6, v); chk("R1", v, 16'h0);
        chk("R1", pad_oe, 11'h000);

        // R2 / R3: vector table in general-purpose mode
        prev_pin = 11'h000;
        for (int i = 0; i < 6; i++) begin
            logic [32:0] vec;
            vec = GV[i];
            host_write(3'd1, {5'h0, vec[32:22]});
            host_write(3'd2, {5'h0, vec[21:11]});
            pad_in = vec[10:0];
            chk("R2", pad_oe, vec[32:22]);
            chk("R2", pad_out, vec[21:11]);
            @(negedge clk);
            host_read(3'd3, v);
            chk("R3", v[10:0], prev_pin);
            @(negedge clk);
            host_read(3'd3, v);
            chk("R3", v[10:0], vec[10:0]);
            prev_pin = vec[10:0];
        end

        // R10: command in mode 0 is ignored
        host_write(3'd6, 16'h0001);
        host_read(3'd6, v);
        chk("R10", v[0], 1'b0);
        chk("R10", pad_oe, 11'h555);
        chk("R10", pad_out, 11'h555);

        // R4: enter bus mode, idle pattern, pin registers kept
        host_write(3'd0, 16'h0001);
        @(negedge clk);
        chk("R4", pad_oe, 11'h700);
        chk("R4", pad_out[10:8], 3'b110);
        host_read(3'd1, v); chk("R4", v[10:0], 11'h555);
        host_read(3'd2, v); chk("R4", v[10:0], 11'h555);
        host_read(3'd0, v); chk("R9", v[0], 1'b1);

        // R5 / R6 / R7 / R8: bus cycles
        bus_cycle(1'b1, 8'h3C, 8'hA7, 4'd3, 8'h00);
        bus_cycle(1'b0, 8'h81, 8'h00, 4'd2, 8'h6E);
        bus_cycle(1'b1, 8'hF0, 8'h0F, 4'd0, 8'h00);
        bus_cycle(1'b0, 8'h5A, 8'h11, 4'd1, 8'hC3);
        bus_cycle(1'b1, 8'h00, 8'hFF, 4'd15, 8'h00);

        // R10: command during a busy cycle is ignored
        host_write(3'd4, 16'h0012);
        host_write(3'd5, 16'h0034);
        host_write(3'd7, 16'h0002);
        host_write(3'd6, 16'h0001);
        host_write(3'd6, 16'h0000);
        for (int i = 1; i <= 4; i++) begin
            chk("R10", pad_out[9], 1'b1);
            @(negedge clk);
        end
        host_read(3'd6, v); chk("R10", v[0], 1'b0);
        @(negedge clk);
        host_read(3'd6, v); chk("R10", v[0], 1'b0);
        chk("R10", pad_out[9], 1'b1);

        // R9: mode change during a cycle is deferred
        host_write(3'd7, 16'h0004);
        host_write(3'd6, 16'h0001);
        host_write(3'd0, 16'h0000);
        for (int i = 1; i <= 6; i++) begin
            chk("R9", pad_oe[10:8], 3'b111);
            host_read(3'd0, v);
            chk("R9", v[0], 1'b1);
            @(negedge clk);
        end
        host_read(3'd0, v); chk("R9", v[0], 1'b1);
        chk("R9", pad_oe, 11'h700);
        @(negedge clk);
        host_read(3'd0, v); chk("R9", v[0], 1'b0);
        chk("R4", pad_oe, 11'h555);
        chk("R4", pad_out, 11'h555);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule